// File: doc/BRIEF.md
# Sub-Word Aliasing Register File

This block holds eight general-purpose 32-bit registers that overlap across three access sizes. Any register can be handled as a whole word, or through its lower 16-bit half. The four data registers also expose the two bytes of that lower half, and each byte can be reached on its own. Index and pointer registers have no byte view. A partial write merges into the stored value and keeps every bit it does not cover.

There is one write port and there are two independent read ports. Each port carries a 3-bit register select and a 2-bit size code. Writes commit on the rising clock edge. Reads are combinational, and narrow reads come back right-aligned and zero-extended onto the 32-bit bus. A byte access that names an index or pointer register is illegal. An illegal write changes nothing and raises a one-cycle error flag. An illegal read reports an error and returns zero.

Top module: `sar_regfile`

## Requirements
- R1: Select codes 0 to 7 name the accumulator, count, data, base, stack pointer, base pointer, source index and destination index. Size code 0 accesses the full 32 bits of the selected register.
- R2: A write with size code 1 stores wr_data[15:0] into bits 15:0 and keeps bits 31:16 of that register unchanged.
- R3: On select codes 0 to 3, size code 2 writes wr_data[7:0] into bits 7:0 only. Size code 3 writes wr_data[7:0] into bits 15:8 only. The other byte and the upper half are kept.
- R4: A byte-sized write (code 2 or 3) to select codes 4 to 7 changes no register. It sets wr_err high for the one cycle after that clock edge.
- R5: Read data is right-aligned and zero-extended. Code 1 returns bits 15:0, code 2 returns bits 7:0 and code 3 returns bits 15:8. A byte-sized read of select codes 4 to 7 raises the port's error output and returns zero.
- R6: The two read ports are combinational and independent of each other. A read of a register that is being written in the same cycle returns the value from before that write.
- R7: Holding rst high across a clock edge clears every register and wr_err to zero.
- R8: While we is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write enable |
| wr_sel | input | 3 | Register select for the write |
| wr_size | input | 2 | Write size code (0 word, 1 half, 2 low byte, 3 high byte) |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | Registered pulse after an illegal write |
| ra_sel | input | 3 | Register select, read port A |
| ra_size | input | 2 | Size code, read port A |
| ra_data | output | 32 | Read data, port A |
| ra_err | output | 1 | Illegal access flag, port A |
| rb_sel | input | 3 | Register select, read port B |
| rb_size | input | 2 | Size code, read port B |
| rb_data | output | 32 | Read data, port B |
| rb_err | output | 1 | Illegal access flag, port B |

## Verification
The bench builds the block with its default parameters: a 32-bit word, eight registers, and byte views on the first four. These defaults put every size code on both sides of the data/pointer boundary within reach. They also allow a full-width pattern whose upper half must survive half and byte writes. The table sequence chains partial writes into one register, so each merge is checked against all earlier ones. Directed tests then cover a read in the same cycle as a write, both ports at once, the error pulse width, and a reset in mid-run.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    SZ_FULL = 2'd0,
    SZ_HALF = 2'd1,
    SZ_LOB  = 2'd2,
    SZ_HIB  = 2'd3
  } acc_size_e;

  function automatic logic is_byte(acc_size_e s);
    return (s == SZ_LOB) || (s == SZ_HIB);
  endfunction
endpackage

// File: rtl/sar_wr_ctrl.sv
`timescale 1ns/1ps
module sar_wr_ctrl
  import sar_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int NDATA = 4,
  localparam int SELW   = $clog2(NREGS),
  localparam int NBYTES = XLEN / 8
) (
  input  logic              we,
  input  logic [SELW-1:0]   sel,
  input  acc_size_e         size,
  input  logic [XLEN-1:0]   data,
  output logic              commit,
  output logic              illegal,
  output logic [NBYTES-1:0] lanes,
  output logic [XLEN-1:0]   aligned
);
  function automatic logic [NBYTES-1:0] lane_mask(acc_size_e s);
    logic [NBYTES-1:0] m;
    case (s)
      SZ_FULL: m = '1;
      SZ_HALF: m = NBYTES'(2'b11);
      SZ_LOB:  m = NBYTES'(2'b01);
      default: m = NBYTES'(2'b10);
    endcase
    return m;
  endfunction

  function automatic logic [XLEN-1:0] place(acc_size_e s, logic [XLEN-1:0] d);
    return (s == SZ_HIB) ? (d << 8) : d;
  endfunction

  assign illegal = we && is_byte(size) && (int'(sel) >= NDATA);
  assign commit  = we && !illegal;
  assign lanes   = lane_mask(size);
  assign aligned = place(size, data);
endmodule

// File: rtl/sar_bank.sv
`timescale 1ns/1ps
module sar_bank #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int SELW   = $clog2(NREGS),
  localparam int NBYTES = XLEN / 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        commit,
  input  logic [SELW-1:0]             sel,
  input  logic [NBYTES-1:0]           lanes,
  input  logic [XLEN-1:0]             wdata,
  output logic [NREGS-1:0][XLEN-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (commit) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (lanes[b]) q[sel][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/sar_rd_port.sv
`timescale 1ns/1ps
module sar_rd_port
  import sar_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int NDATA = 4,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][XLEN-1:0] bank,
  input  logic [SELW-1:0]            sel,
  input  acc_size_e                  size,
  output logic [XLEN-1:0]            data,
  output logic                       err
);
  function automatic logic [XLEN-1:0] narrow(logic [XLEN-1:0] w, acc_size_e s);
    logic [XLEN-1:0] r;
    r = '0;
    case (s)
      SZ_FULL: r = w;
      SZ_HALF: r[15:0] = w[15:0];
      SZ_LOB:  r[7:0] = w[7:0];
      default: r[7:0] = w[15:8];
    endcase
    return r;
  endfunction

  assign err  = is_byte(size) && (int'(sel) >= NDATA);
  assign data = err ? '0 : narrow(bank[sel], size);
endmodule

// File: rtl/sar_regfile.sv
`timescale 1ns/1ps
module sar_regfile
  import sar_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int NDATA = 4,
  localparam int SELW   = $clog2(NREGS),
  localparam int NBYTES = XLEN / 8,
  localparam int NRD    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] wr_sel,
  input  logic [1:0]      wr_size,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_err,
  input  logic [SELW-1:0] ra_sel,
  input  logic [1:0]      ra_size,
  output logic [XLEN-1:0] ra_data,
  output logic            ra_err,
  input  logic [SELW-1:0] rb_sel,
  input  logic [1:0]      rb_size,
  output logic [XLEN-1:0] rb_data,
  output logic            rb_err
);
  // Named internal events, visible to the bound checker
  logic                       wr_commit;
  logic                       wr_illegal;
  logic [NBYTES-1:0]          wr_lanes;
  logic [XLEN-1:0]            wr_aligned;
  logic [NREGS-1:0][XLEN-1:0] bank_q;

  sar_wr_ctrl #(.XLEN(XLEN), .NREGS(NREGS), .NDATA(NDATA)) u_wr (
    .we      (we),
    .sel     (wr_sel),
    .size    (acc_size_e'(wr_size)),
    .data    (wr_data),
    .commit  (wr_commit),
    .illegal (wr_illegal),
    .lanes   (wr_lanes),
    .aligned (wr_aligned)
  );

  sar_bank #(.XLEN(XLEN), .NREGS(NREGS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .commit (wr_commit),
    .sel    (wr_sel),
    .lanes  (wr_lanes),
    .wdata  (wr_aligned),
    .q      (bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_illegal;
  end

  logic [NRD-1:0][SELW-1:0] rd_sel;
  logic [NRD-1:0][1:0]      rd_size;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  logic [NRD-1:0]           rd_err;

  assign rd_sel  = {rb_sel, ra_sel};
  assign rd_size = {rb_size, ra_size};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    sar_rd_port #(.XLEN(XLEN), .NREGS(NREGS), .NDATA(NDATA)) u_rd (
      .bank (bank_q),
      .sel  (rd_sel[p]),
      .size (acc_size_e'(rd_size[p])),
      .data (rd_data[p]),
      .err  (rd_err[p])
    );
  end

  assign ra_data = rd_data[0];
  assign ra_err  = rd_err[0];
  assign rb_data = rd_data[1];
  assign rb_err  = rd_err[1];
endmodule

// File: rtl/sar_regfile_chk.sv
`timescale 1ns/1ps
module sar_regfile_chk #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int NDATA = 4,
  localparam int SELW = $clog2(NREGS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       we,
  input logic [SELW-1:0]            wr_sel,
  input logic [1:0]                 wr_size,
  input logic                       wr_err,
  input logic [XLEN-1:0]            ra_data,
  input logic                       ra_err,
  input logic [1:0]                 ra_size,
  input logic [XLEN-1:0]            rb_data,
  input logic                       rb_err,
  input logic [1:0]                 rb_size,
  input logic [NREGS-1:0][XLEN-1:0] bank_q
);
  logic [NREGS-1:0][XLEN-17:0] uppers;
  logic [NREGS-1:0][7:0]       byte0s;
  logic [NREGS-1:0][7:0]       byte1s;
  logic                        bad_wr;

  for (genvar r = 0; r < NREGS; r++) begin : g_split
    assign uppers[r] = bank_q[r][XLEN-1:16];
    assign byte0s[r] = bank_q[r][7:0];
    assign byte1s[r] = bank_q[r][15:8];
  end

  assign bad_wr = we && wr_size[1] && (int'(wr_sel) >= NDATA);

  // R4
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> wr_err);

  // R4
  flag_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(bad_wr));

  // R4
  illegal_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> $stable(bank_q));

  // R8
  idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bank_q));

  // R2
  half_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'd1) |=> $stable(uppers));

  // R3
  low_byte_scope_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'd2) |=> ($stable(uppers) && $stable(byte1s)));

  // R3
  high_byte_scope_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_size == 2'd3) |=> ($stable(uppers) && $stable(byte0s)));

  // R5
  ra_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ra_err |-> (ra_data == '0));

  // R5
  rb_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rb_err |-> (rb_data == '0));

  // R5
  ra_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_size != 2'd0) |-> (ra_data[XLEN-1:16] == '0));

  // R5
  rb_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rb_size != 2'd0) |-> (rb_data[XLEN-1:16] == '0));
endmodule

bind sar_regfile sar_regfile_chk #(.XLEN(XLEN), .NREGS(NREGS), .NDATA(NDATA)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .we      (we),
  .wr_sel  (wr_sel),
  .wr_size (wr_size),
  .wr_err  (wr_err),
  .ra_data (ra_data),
  .ra_err  (ra_err),
  .ra_size (ra_size),
  .rb_data (rb_data),
  .rb_err  (rb_err),
  .rb_size (rb_size),
  .bank_q  (bank_q)
);

// File: tb/sar_regfile_tb.sv
`timescale 1ns/1ps
module sar_regfile_tb;
  localparam int XLEN = 32;
  localparam int NV   = 17;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            we = 1'b0;
  logic [2:0]      wr_sel = '0;
  logic [1:0]      wr_size = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic            wr_err;
  logic [2:0]      ra_sel = '0;
  logic [1:0]      ra_size = '0;
  logic [XLEN-1:0] ra_data;
  logic            ra_err;
  logic [2:0]      rb_sel = '0;
  logic [1:0]      rb_size = '0;
  logic [XLEN-1:0] rb_data;
  logic            rb_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sar_regfile u_dut (
    .clk(clk), .rst(rst), .we(we), .wr_sel(wr_sel), .wr_size(wr_size),
    .wr_data(wr_data), .wr_err(wr_err),
    .ra_sel(ra_sel), .ra_size(ra_size), .ra_data(ra_data), .ra_err(ra_err),
    .rb_sel(rb_sel), .rb_size(rb_size), .rb_data(rb_data), .rb_err(rb_err)
  );

  // {we, wsel, wsize, wdata, rsel, rsize, expected read on port A}
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 3'd0, 2'd0, 32'h11223344, 3'd0, 2'd0, 32'h11223344}, // R1
    {1'b1, 3'd0, 2'd1, 32'h0000AABB, 3'd0, 2'd0, 32'h1122AABB}, // R2
    {1'b1, 3'd0, 2'd2, 32'h000000CC, 3'd0, 2'd0, 32'h1122AACC}, // R3
    {1'b1, 3'd0, 2'd3, 32'h000000DD, 3'd0, 2'd0, 32'h1122DDCC}, // R3
    {1'b0, 3'd0, 2'd0, 32'h0,        3'd0, 2'd3, 32'h000000DD}, // R5
    {1'b0, 3'd0, 2'd0, 32'h0,        3'd0, 2'd2, 32'h000000CC}, // R5
    {1'b0, 3'd0, 2'd0, 32'h0,        3'd0, 2'd1, 32'h0000DDCC}, // R5
    {1'b1, 3'd4, 2'd0, 32'hCAFEF00D, 3'd4, 2'd0, 32'hCAFEF00D}, // R1
    {1'b1, 3'd4, 2'd2, 32'h00000055, 3'd4, 2'd0, 32'hCAFEF00D}, // R4
    {1'b1, 3'd4, 2'd1, 32'h00001234, 3'd4, 2'd0, 32'hCAFE1234}, // R2
    {1'b1, 3'd7, 2'd3, 32'h00000077, 3'd7, 2'd0, 32'h00000000}, // R4
    {1'b1, 3'd3, 2'd0, 32'hFFFFFFFF, 3'd3, 2'd0, 32'hFFFFFFFF}, // R1
    {1'b1, 3'd3, 2'd3, 32'h00000000, 3'd3, 2'd0, 32'hFFFF00FF}, // R3
    {1'b1, 3'd1, 2'd1, 32'hFFFF5678, 3'd1, 2'd0, 32'h00005678}, // R2
    {1'b1, 3'd2, 2'd2, 32'h123456AB, 3'd2, 2'd0, 32'h000000AB}, // R3
    {1'b0, 3'd4, 2'd0, 32'h00000000, 3'd4, 2'd0, 32'hCAFE1234}, // R8
    {1'b0, 3'd0, 2'd0, 32'h0,        3'd2, 2'd2, 32'h000000AB}  // R5
  };

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // Reset state, R7
    repeat (3) @(negedge clk);
    #1;
    check("R7 wr_err in reset", {31'd0, wr_err}, 32'd0);
    for (int r = 0; r < 8; r++) begin
      ra_sel = 3'(r);
      #0.1;
      check("R7 register cleared", ra_data, 32'd0);
    end
    @(negedge clk);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we      = VEC[i][74];
      wr_sel  = VEC[i][73:71];
      wr_size = VEC[i][70:69];
      wr_data = VEC[i][68:37];
      @(negedge clk);
      we      = 1'b0;
      ra_sel  = VEC[i][36:34];
      ra_size = VEC[i][33:32];
      #1;
      check($sformatf("vector %0d (R1 R2 R3 R4 R5 R8)", i), ra_data, VEC[i][31:0]);
    end

    // R6: same-cycle read returns the old value
    @(negedge clk);
    we = 1'b1; wr_sel = 3'd7; wr_size = 2'd0; wr_data = 32'hA5A5A5A5;
    ra_sel = 3'd7; ra_size = 2'd0;
    #1;
    check("R6 read during write is old", ra_data, 32'h0);
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R6 read after write is new", ra_data, 32'hA5A5A5A5);

    // R6: both ports at once
    ra_sel = 3'd4; ra_size = 2'd0;
    rb_sel = 3'd0; rb_size = 2'd0;
    #1;
    check("R6 port A", ra_data, 32'hCAFE1234);
    check("R6 port B", rb_data, 32'h1122DDCC);
    rb_sel = 3'd3; rb_size = 2'd1;
    #1;
    check("R5 port B half", rb_data, 32'h000000FF);
    rb_size = 2'd3;
    #1;
    check("R5 port B high byte", rb_data, 32'h0);

    // R5: illegal read
    ra_sel = 3'd6; ra_size = 2'd3;
    #1;
    check("R5 ra_err on pointer byte", {31'd0, ra_err}, 32'd1);
    check("R5 zero data on error", ra_data, 32'd0);
    rb_sel = 3'd5; rb_size = 2'd2;
    #1;
    check("R5 rb_err on pointer byte", {31'd0, rb_err}, 32'd1);
    ra_sel = 3'd2;
    #1;
    check("R5 no error on data byte", {31'd0, ra_err}, 32'd0);

    // R4: error pulse width
    @(negedge clk);
    we = 1'b1; wr_sel = 3'd5; wr_size = 2'd2; wr_data = 32'hFF;
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R4 wr_err raised", {31'd0, wr_err}, 32'd1);
    ra_sel = 3'd5; ra_size = 2'd0;
    #0.1;
    check("R4 base pointer untouched", ra_data, 32'd0);
    @(negedge clk);
    #1;
    check("R4 wr_err one cycle", {31'd0, wr_err}, 32'd0);
    @(negedge clk);
    we = 1'b1; wr_sel = 3'd1; wr_size = 2'd3; wr_data = 32'h12;
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R4 no flag on legal byte write", {31'd0, wr_err}, 32'd0);
    ra_sel = 3'd1;
    #0.1;
    check("R3 count high byte", ra_data, 32'h00001278);

    // R7: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ra_sel = 3'd0; ra_size = 2'd0;
    rb_sel = 3'd4; rb_size = 2'd0;
    #1;
    check("R7 accumulator cleared", ra_data, 32'd0);
    check("R7 stack pointer cleared", rb_data, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule